// File: doc/BRIEF.md
# Mailbox Memory Write Engine with Running CRC-16

This block lets an external host fill an on-chip memory one 32-bit word at a time through a small map of 16-bit registers. The host loads a target byte address into two address registers, which must be word aligned. It then places a word in two data registers and issues a commit command. The engine writes the word to memory through a single-cycle write port and moves its internal word pointer forward. This lets a long image be streamed without the address being written again.

Each committed word is also folded into a CRC-16 (polynomial 0x1021, MSB first, no reflection, no final inversion), four bytes in big-endian order. The fold is byte-serial, so the engine reports busy for four cycles per word. When the stream ends, the host reads the CRC and compares it with its own value. A dedicated bit in the control register clears the CRC before a new transfer.

Top module: `mbox_wr_engine`

## Requirements
- R1: After reset, mem_we is 0 and every mapped register (control 0x200, CRC 0x201, address 0x202/0x203, data 0x204/0x205) reads 0x0000.
- R2: Register 0x202 holds address bits 31:16. Register 0x203 holds address bits 15:2 and reads bits 1:0 as 0. Register 0x204 holds data bits 31:16 and register 0x205 holds data bits 15:0. All four read back what was written. An unmapped register address reads 0x0000.
- R3: A write to 0x200 with bit 15 (execute) and bit 14 (write) both set, while idle, raises mem_we for exactly the one cycle after that write. During that cycle mem_wdata is the data word held at the write and mem_addr is the current word pointer, with bits 1:0 equal to 0.
- R4: Bit 8 of register 0x200 (busy) is 1 for exactly four cycles, starting with the cycle after a commit. Bits 15, 14 and 12 of 0x200 always read 0, so during those cycles 0x200 reads exactly 0x0100.
- R5: A commit issued while busy has no effect: no memory write, no pointer move, no CRC change. A write of execute without the write bit also has no effect.
- R6: The word pointer advances by one word (4 bytes) after each commit and wraps from 0xFFFFFFFC to 0x00000000. Writing either address register reloads the pointer from both address registers, using the new value of the one just written.
- R7: Register 0x201 returns the CRC-16 (poly 0x1021, MSB first, no reflection, no final XOR) of all committed words since the last clear. Each word enters most significant byte first. The value is final once busy has dropped.
- R8: Writing bit 12 of 0x200 while idle clears the CRC to 0x0000, and the bit reads back as 0. When bit 12 is set together with a commit, the CRC is cleared first and then the new word is folded in. While busy, a clear request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_addr | input | REG_AW (12) | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| mem_we | output | 1 | Memory write enable, one-cycle pulse |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore drives on the falling edge and samples one falling edge later. At that point mem_we, mem_addr and mem_wdata for a commit are due, and busy is already set. Busy is read at that sample and at the three after it, each expected high, and at the fifth sample it must be low. Only then is the CRC read and compared with a bit-serial model in the bench. Register reads are combinational, so each one is sampled shortly after reg_addr changes, within the same low clock phase.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Register offsets inside the mailbox window
  localparam int OFS_CTRL = 'h200;
  localparam int OFS_CRC  = 'h201;
  localparam int OFS_AHI  = 'h202;
  localparam int OFS_ALO  = 'h203;
  localparam int OFS_DHI  = 'h204;
  localparam int OFS_DLO  = 'h205;

  // Control register bit positions
  localparam int BIT_EXEC   = 15;
  localparam int BIT_WRITE  = 14;
  localparam int BIT_CRCCLR = 12;
  localparam int BIT_BUSY   = 8;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic commit;      // accepted execute+write
    logic exec_try;    // execute+write seen, whether accepted or not
    logic crc_clr;     // accepted CRC clear
    logic ld_ahi;
    logic ld_alo;
    logic ld_dhi;
    logic ld_dlo;
  } reg_strobe_t;

endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int unsigned REG_AW = 12,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic [REG_W-1:0]  crc_val,
  output reg_strobe_t       stb,
  output logic [REG_W-1:0]  addr_hi,
  output logic [REG_W-3:0]  addr_lo,
  output logic [2*REG_W-1:0] data_word,
  output logic [REG_W-1:0]  reg_rdata
);

  localparam int unsigned NHALF = 2;

  logic sel_ctrl, sel_crc, sel_ahi, sel_alo;
  logic [NHALF-1:0] sel_dat;
  logic [NHALF-1:0] ld_dat;
  logic [REG_W-1:0] dat_q [NHALF];

  assign sel_ctrl = (reg_addr == REG_AW'(OFS_CTRL));
  assign sel_crc  = (reg_addr == REG_AW'(OFS_CRC));
  assign sel_ahi  = (reg_addr == REG_AW'(OFS_AHI));
  assign sel_alo  = (reg_addr == REG_AW'(OFS_ALO));

  // Strobes
  always_comb begin
    stb          = '0;
    stb.exec_try = reg_wr && sel_ctrl && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE];
    stb.commit   = stb.exec_try && !busy;
    stb.crc_clr  = reg_wr && sel_ctrl && reg_wdata[BIT_CRCCLR] && !busy;
    stb.ld_ahi   = reg_wr && sel_ahi;
    stb.ld_alo   = reg_wr && sel_alo;
    stb.ld_dhi   = ld_dat[NHALF-1];
    stb.ld_dlo   = ld_dat[0];
  end

  // Address holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_hi <= '0;
    else if (stb.ld_ahi) addr_hi <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_lo <= '0;
    else if (stb.ld_alo) addr_lo <= reg_wdata[REG_W-1:2];
  end

  // Data halves: index 1 is the upper half, index 0 the lower half
  for (genvar h = 0; h < NHALF; h++) begin : g_dat
    localparam int OFS_H = (h == 0) ? OFS_DLO : OFS_DHI;
    assign sel_dat[h] = (reg_addr == REG_AW'(OFS_H));
    assign ld_dat[h]  = reg_wr && sel_dat[h];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dat_q[h] <= '0;
      else if (ld_dat[h]) dat_q[h] <= reg_wdata;
    end

    assign data_word[h*REG_W +: REG_W] = dat_q[h];
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)        reg_rdata[BIT_BUSY] = busy;
    else if (sel_crc)    reg_rdata = crc_val;
    else if (sel_ahi)    reg_rdata = addr_hi;
    else if (sel_alo)    reg_rdata = {addr_lo, 2'b00};
    else if (sel_dat[1]) reg_rdata = dat_q[1];
    else if (sel_dat[0]) reg_rdata = dat_q[0];
  end

  p_alo_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.ld_alo |=> addr_lo == $past(reg_wdata[REG_W-1:2]));

  p_dhi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel_dat[1]) |=> $stable(dat_q[1]));

endmodule

// File: rtl/mbox_addr_ctr.sv
module mbox_addr_ctr #(
  parameter int unsigned WA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [WA_W-1:0] reload_val,
  input  logic            inc,
  output logic [WA_W-1:0] word_q
);

  logic [WA_W-1:0] word_d;
  logic            word_en;

  always_comb begin
    word_en = reload || inc;
    word_d  = word_q;
    if (reload)   word_d = reload_val;
    else if (inc) word_d = word_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !reload) |=> word_q == $past(word_q) + 1'b1);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> word_q == $past(reload_val));

endmodule

// File: rtl/mbox_crc16.sv
module mbox_crc16 #(
  parameter logic [15:0] POLY   = 16'h1021,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              step,
  output logic [15:0]       crc
);

  localparam int unsigned BYTE_W = 8;

  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sh_en;
  logic [15:0]       crc_d;
  logic              crc_en;

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[15] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r;
  endfunction

  // Byte shifter: most significant byte leaves first
  always_comb begin
    sh_en = load || step;
    sh_d  = sh_q;
    if (load)      sh_d = word_in;
    else if (step) sh_d = sh_q << BYTE_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_comb begin
    crc_en = clr || step;
    crc_d  = crc;
    if (clr)       crc_d = '0;
    else if (step) crc_d = fold_byte(crc, sh_q[WORD_W-1 -: BYTE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (crc_en) crc <= crc_d;
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == 16'h0000);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(crc));

endmodule

// File: rtl/mbox_wr_engine.sv
module mbox_wr_engine
  import mbox_pkg::*;
#(
  parameter int unsigned REG_AW   = 12,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata
);

  localparam int unsigned REG_W  = 16;
  localparam int unsigned WORD_W = 2 * REG_W;
  localparam int unsigned ADDR_W = 2 * REG_W;
  localparam int unsigned WA_W   = ADDR_W - 2;
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned CNT_W  = $clog2(NBYTES);

  reg_strobe_t        stb;
  logic [REG_W-1:0]   addr_hi;
  logic [REG_W-3:0]   addr_lo;
  logic [WORD_W-1:0]  data_word;
  logic [15:0]        crc_val;
  logic               busy;

  seq_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               we_q;
  logic [WORD_W-1:0]  wd_q;
  logic               reload;
  logic [WA_W-1:0]    reload_val;
  logic [WA_W-1:0]    word_ptr;

  mbox_regfile #(.REG_AW(REG_AW), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .crc_val   (crc_val),
    .stb       (stb),
    .addr_hi   (addr_hi),
    .addr_lo   (addr_lo),
    .data_word (data_word),
    .reg_rdata (reg_rdata)
  );

  // Sequencer: one run of NBYTES CRC steps per accepted commit
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (stb.commit) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end
      end
      SEQ_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(NBYTES - 1)) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == SEQ_RUN);

  // Memory write pulse and captured word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= stb.commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wd_q <= '0;
    else if (stb.commit) wd_q <= data_word;
  end

  // Pointer reload takes the freshly written half from the bus
  assign reload     = stb.ld_ahi || stb.ld_alo;
  assign reload_val = {(stb.ld_ahi ? reg_wdata : addr_hi),
                       (stb.ld_alo ? reg_wdata[REG_W-1:2] : addr_lo)};

  mbox_addr_ctr #(.WA_W(WA_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload),
    .reload_val (reload_val),
    .inc        (we_q),
    .word_q     (word_ptr)
  );

  mbox_crc16 #(.POLY(CRC_POLY), .WORD_W(WORD_W)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (stb.crc_clr),
    .load    (stb.commit),
    .word_in (data_word),
    .step    (busy),
    .crc     (crc_val)
  );

  assign mem_we    = we_q;
  assign mem_addr  = {word_ptr, 2'b00};
  assign mem_wdata = wd_q;

  // Checker state: length of the current busy run
  logic [CNT_W:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_run <= '0;
    else if (busy) chk_run <= chk_run + 1'b1;
    else           chk_run <= '0;
  end

  p_we_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_busy_starts_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_we);

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> chk_run < (CNT_W+1)'(NBYTES));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(chk_run) == (CNT_W+1)'(NBYTES - 1));

  p_ignore_busy_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stb.exec_try) |=> !mem_we);

endmodule

// File: tb/sim_mbox_wr_engine.sv
`timescale 1ns/1ps
module sim_mbox_wr_engine;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h200;
  localparam logic [11:0] A_CRC  = 12'h201;
  localparam logic [11:0] A_AHI  = 12'h202;
  localparam logic [11:0] A_ALO  = 12'h203;
  localparam logic [11:0] A_DHI  = 12'h204;
  localparam logic [11:0] A_DLO  = 12'h205;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned we_cnt = 0;
  int unsigned exp_we = 0;
  logic [31:0] exp_addr;
  logic [15:0] exp_crc;
  logic [15:0] hi_shadow, lo_shadow;
  logic [15:0] dhi_shadow, dlo_shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_wr_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) we_cnt++;

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[15] ^ w[i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic set_hi(input logic [15:0] v);
    wr(A_AHI, v); hi_shadow = v;
    exp_addr = {hi_shadow, lo_shadow};
  endtask

  task automatic set_lo(input logic [15:0] v);
    wr(A_ALO, v); lo_shadow = v & 16'hFFFC;
    exp_addr = {hi_shadow, lo_shadow};
  endtask

  task automatic put_word(input logic [31:0] w);
    wr(A_DHI, w[31:16]); dhi_shadow = w[31:16];
    wr(A_DLO, w[15:0]);  dlo_shadow = w[15:0];
  endtask

  // Issue a commit with current held data and check the whole response
  task automatic go(input logic [15:0] cmd);
    logic [31:0] w = {dhi_shadow, dlo_shadow};
    logic [15:0] v;
    wr(A_CTRL, cmd);
    chk(mem_we === 1'b1, "R3 we pulse", mem_we, 1);
    chk(mem_addr === exp_addr, "R6 address", mem_addr, exp_addr);
    chk(mem_wdata === w, "R3 data", mem_wdata, w);
    if (cmd[12]) exp_crc = 16'h0000;
    exp_crc  = crc_word(exp_crc, w);
    exp_addr = exp_addr + 32'd4;
    exp_we++;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk(reg_rdata === 16'h0100, "R4 busy high", reg_rdata, 16'h0100);
    end
    @(negedge clk); #1;
    chk(reg_rdata === 16'h0000, "R4 busy low", reg_rdata, 0);
    chk(mem_we === 1'b0, "R3 single pulse", mem_we, 0);
    rd(A_CRC, v);
    chk(v === exp_crc, "R7 crc", v, exp_crc);
  endtask

  task automatic commit_word(input logic [31:0] w);
    put_word(w);
    go(16'hC000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    hi_shadow = '0; lo_shadow = '0; dhi_shadow = '0; dlo_shadow = '0;
    exp_addr = '0; exp_crc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    chk(mem_we === 1'b0, "R1 mem_we", mem_we, 0);
    rd(A_CTRL, v); chk(v === 16'h0, "R1 ctrl", v, 0);
    rd(A_CRC, v);  chk(v === 16'h0, "R1 crc", v, 0);
    rd(A_AHI, v);  chk(v === 16'h0, "R1 ahi", v, 0);
    rd(A_ALO, v);  chk(v === 16'h0, "R1 alo", v, 0);
    rd(A_DHI, v);  chk(v === 16'h0, "R1 dhi", v, 0);
    rd(A_DLO, v);  chk(v === 16'h0, "R1 dlo", v, 0);

    // R2 readback sweep over walking and mixed patterns
    for (int i = 0; i < 20; i++) begin
      logic [15:0] p = (i < 16) ? (16'h1 << i) : (16'hA5C3 ^ 16'(i * 16'h1357));
      set_hi(p);     rd(A_AHI, v); chk(v === p, "R2 ahi", v, p);
      set_lo(~p);    rd(A_ALO, v); chk(v === (~p & 16'hFFFC), "R2 alo", v, ~p & 16'hFFFC);
      put_word({p, ~p});
      rd(A_DHI, v); chk(v === p, "R2 dhi", v, p);
      rd(A_DLO, v); chk(v === ~p, "R2 dlo", v, ~p);
    end
    rd(12'h206, v); chk(v === 16'h0, "R2 unmapped 206", v, 0);
    rd(12'h1FF, v); chk(v === 16'h0, "R2 unmapped 1FF", v, 0);
    rd(12'h000, v); chk(v === 16'h0, "R2 unmapped 000", v, 0);

    // R8 clear while idle, no memory side effect
    set_hi(16'h0001); set_lo(16'h0040);
    wr(A_CTRL, 16'h1000);
    chk(mem_we === 1'b0, "R8 clear writes nothing", mem_we, 0);
    exp_crc = 16'h0000;
    rd(A_CRC, v);  chk(v === 16'h0, "R8 crc cleared", v, 0);
    rd(A_CTRL, v); chk(v === 16'h0, "R8 clear bit reads 0", v, 0);

    // R7 byte order: these two words must give different CRCs
    commit_word(32'h0000_0001);
    commit_word(32'h0100_0000);
    commit_word(32'hFFFF_FFFF);
    commit_word(32'h0000_0000);

    // R6/R7 stream of consecutive words
    w = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      w = w * 32'h0019_660D + 32'h3C6E_F35F;
      commit_word(w);
    end

    // R5 execute without write bit
    wr(A_CTRL, 16'h8000);
    chk(mem_we === 1'b0, "R5 exec alone", mem_we, 0);
    repeat (5) @(negedge clk); #1;
    chk(we_cnt == exp_we, "R5 exec alone count", we_cnt, exp_we);
    rd(A_CRC, v); chk(v === exp_crc, "R5 exec alone crc", v, exp_crc);

    // R5/R8 commit and clear during busy are dropped
    commit_word(32'hCAFE_F00D);
    put_word(32'h1111_2222);
    go(16'hC000);
    // busy run just finished inside go; start another and hit it while busy
    put_word(32'h3333_4444);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 16'hC000;
    @(negedge clk);
    reg_wdata = 16'hC000;                 // second commit while busy
    @(negedge clk);
    reg_wdata = 16'h1000;                 // clear while busy
    @(negedge clk);
    reg_wr = 1'b0;
    exp_crc = crc_word(exp_crc, 32'h3333_4444);
    exp_addr = exp_addr + 32'd4;
    exp_we++;
    repeat (5) @(negedge clk); #1;
    chk(we_cnt == exp_we, "R5 busy commit count", we_cnt, exp_we);
    rd(A_CRC, v); chk(v === exp_crc, "R8 busy clear ignored", v, exp_crc);
    commit_word(32'h5555_6666);           // pointer moved once only

    // R8 clear combined with commit
    put_word(32'hBEEF_0042);
    go(16'hD000);
    commit_word(32'h0BAD_C0DE);

    // R6 reload from low half only, then wrap
    set_lo(16'h0102);
    commit_word(32'h7777_8888);
    set_hi(16'hFFFF); set_lo(16'hFFFC);
    commit_word(32'h9999_AAAA);
    chk(exp_addr === 32'h0, "R6 wrap model", exp_addr, 0);
    commit_word(32'hBBBB_CCCC);

    finish_run();
  end

endmodule